// File: doc/BRIEF.md
# Revolution-Locked Loss Event Histogrammer

This block builds a histogram of beam-loss detector events over the time slots of one machine revolution. Each digitized sample is compared with a programmable threshold. A rising crossing of that threshold is one event. A bin strobe, which comes from a reference clock and not from the sample clock, moves a bin index through the revolution, one slot per strobe. A revolution marker returns the index to slot zero. In full deployment the revolution has 57024 slots, each one sixteenth of a bunch length. The default slot count is kept small so that the default elaboration stays small.

Every slot has a saturating counter, 20 to 24 bits wide in deployment. A slot's counter goes up by at most one per pass through that slot. Two counter banks alternate. Once per update period (nominally one second) the bank that has been accumulating is frozen for readout. The other bank is then cleared, one address per clock, and becomes the new accumulation bank. A scaler of all events, a count of events that arrived while the bank was clearing, an overflow flag and a missed-marker flag are frozen at the same moment. A registered address/data port reads the frozen bank.

Top module: `turn_hist`

## Requirements
- R1: An event is a cycle in which `sample_valid` is 1, `sample > threshold` (unsigned), and the previous valid sample was not above the threshold. Before the first valid sample after reset, the level counts as not above. Cycles with `sample_valid` at 0 produce no event and leave the previous-level state unchanged.
- R2: The bin index is 0 after reset. Each `bin_tick` adds one to the index. `rev_mark` sets the index to 0 and wins over a `bin_tick` in the same cycle. A `bin_tick` at index NUM_BINS-1 without `rev_mark` wraps the index to 0.
- R3: A bin closes in any cycle with `bin_tick` or `rev_mark`. When a bin closes, its counter in the accumulation bank goes up by exactly one if at least one event occurred in that bin, including the closing cycle. It is otherwise unchanged.
- R4: Bin counters stop at all-ones. `snap_overflow` reports whether, during the period, any bin update found its counter already at all-ones.
- R5: A snapshot takes place at the end of every PERIOD clock cycles after reset, so the first one ends cycle PERIOD. `snap_ready` is a one-cycle pulse in the cycle after the snapshot edge. From that cycle on, `snap_*` and the read port show the frozen period.
- R6: If a bin is still open at the snapshot edge and already holds an event, its count is added to the bank being frozen.
- R7: For NUM_BINS cycles after reset and after each snapshot edge, the accumulation bank is cleared. During this time no bin counter is updated. Events are counted in a spill counter, and `snap_spill` reports that counter at the next snapshot.
- R8: `snap_total` is the number of events in the period, including those in the snapshot cycle, and stops at all-ones.
- R9: `rd_data` equals the frozen bank's counter at `rd_addr`, one cycle after `rd_addr` is presented. Accumulation and clearing do not disturb it. It is defined only from the cycle after the first `snap_ready`.
- R10: `snap_missed` is 1 if any index wrap of R2 occurred without `rev_mark` during the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Sample qualifier |
| sample | input | SAMPLE_W | Digitized detector sample |
| threshold | input | SAMPLE_W | Event threshold code |
| bin_tick | input | 1 | Advance to the next time slot |
| rev_mark | input | 1 | Revolution start marker |
| rd_addr | input | $clog2(NUM_BINS) | Readout slot address |
| rd_data | output | CNT_W | Frozen slot count |
| snap_ready | output | 1 | Pulse when a new frozen bank is readable |
| snap_total | output | CNT_W | Events in the frozen period |
| snap_spill | output | CNT_W | Events seen while clearing in that period |
| snap_overflow | output | 1 | A slot counter saturated in that period |
| snap_missed | output | 1 | The index wrapped without a marker in that period |

## Verification
The bench drives long runs of strobes every cycle with events on alternate cycles, so some counters pass all-ones. A design that wraps would show small counts and a clear overflow flag. Random strobes and markers make `rev_mark` and `bin_tick` coincide at the last slot, and include stretches with no markers. These catch a wrong priority or a missing wrap flag. Events that fall in the clearing window, in the snapshot cycle and in a bin that is open at the snapshot show whether each is routed to spill, total or the outgoing bank. A design that gets this wrong would gain or lose counts at the period boundary. Repeated samples above threshold and gaps in `sample_valid` check that only rising crossings count.

// File: rtl/turn_hist.sv
module turn_hist #(
  parameter int NUM_BINS = 1024,
  parameter int CNT_W    = 24,
  parameter int SAMPLE_W = 10,
  parameter int PERIOD   = 50000000,
  localparam int IDX_W   = $clog2(NUM_BINS),
  localparam int PER_W   = $clog2(PERIOD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic                bin_tick,
  input  logic                rev_mark,
  input  logic [IDX_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]    rd_data,
  output logic                snap_ready,
  output logic [CNT_W-1:0]    snap_total,
  output logic [CNT_W-1:0]    snap_spill,
  output logic                snap_overflow,
  output logic                snap_missed
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] bank0 [NUM_BINS];
  logic [CNT_W-1:0] bank1 [NUM_BINS];
  logic             acc_sel, prev_above, hit, clearing, ovf_acc, miss_acc;
  logic [IDX_W-1:0] idx, clr_addr;
  logic [PER_W-1:0] pcnt;
  logic [CNT_W-1:0] total, spill;

  wire              above     = sample_valid && (sample > threshold);
  wire              ev        = above && !prev_above;
  wire              close_bin = bin_tick || rev_mark;
  wire              snap      = (pcnt == PER_W'(PERIOD - 1));
  wire              last_bin  = (idx == IDX_W'(NUM_BINS - 1));
  wire              wrap_miss = bin_tick && !rev_mark && last_bin;
  wire              commit    = !clearing && (close_bin || snap) && (hit || ev);
  wire [CNT_W-1:0]  cur       = acc_sel ? bank1[idx] : bank0[idx];
  wire              cur_full  = (cur == CMAX);
  wire              sat_hit   = commit && cur_full;
  wire              we        = clearing || commit;
  wire [IDX_W-1:0]  waddr     = clearing ? clr_addr : idx;
  wire [CNT_W-1:0]  wval      = clearing ? '0 : cur + CNT_W'(!cur_full);
  wire [CNT_W-1:0]  total_nx  = total + CNT_W'(ev && (total != CMAX));

  always_ff @(posedge clk) begin
    if (we) begin
      if (acc_sel) bank1[waddr] <= wval;
      else         bank0[waddr] <= wval;
    end
    rd_data <= acc_sel ? bank0[rd_addr] : bank1[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sel       <= 1'b0;
      prev_above    <= 1'b0;
      hit           <= 1'b0;
      clearing      <= 1'b1;
      clr_addr      <= '0;
      idx           <= '0;
      pcnt          <= '0;
      total         <= '0;
      spill         <= '0;
      ovf_acc       <= 1'b0;
      miss_acc      <= 1'b0;
      snap_ready    <= 1'b0;
      snap_total    <= '0;
      snap_spill    <= '0;
      snap_overflow <= 1'b0;
      snap_missed   <= 1'b0;
    end else begin
      if (sample_valid) prev_above <= above;
      hit <= (clearing || snap || close_bin) ? 1'b0 : (hit || ev);

      if (rev_mark)      idx <= '0;
      else if (bin_tick) idx <= last_bin ? '0 : idx + 1'b1;

      if (snap) begin
        clearing <= 1'b1;
        clr_addr <= '0;
      end else if (clearing) begin
        clr_addr <= clr_addr + 1'b1;
        if (clr_addr == IDX_W'(NUM_BINS - 1)) clearing <= 1'b0;
      end

      pcnt       <= snap ? '0 : pcnt + 1'b1;
      snap_ready <= snap;

      if (snap) begin
        acc_sel       <= !acc_sel;
        snap_total    <= total_nx;
        snap_spill    <= spill;
        snap_overflow <= ovf_acc || sat_hit;
        snap_missed   <= miss_acc || wrap_miss;
        total         <= '0;
        spill         <= '0;
        ovf_acc       <= 1'b0;
        miss_acc      <= 1'b0;
      end else begin
        total <= total_nx;
        if (clearing && ev && (spill != CMAX)) spill <= spill + 1'b1;
        if (sat_hit)   ovf_acc  <= 1'b1;
        if (wrap_miss) miss_acc <= 1'b1;
      end
    end
  end

  assert_mark_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rev_mark |=> (idx == '0));

  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ready |=> !snap_ready);

  assert_clear_on_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ready |-> (clearing && clr_addr == '0));

  assert_total_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> (total >= $past(total)));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_acc && !snap) |=> ovf_acc);
endmodule

// File: tb/turn_hist_tb.sv
module turn_hist_tb;
  localparam int NB     = 8;
  localparam int CW     = 4;
  localparam int SW     = 10;
  localparam int PERIOD = 200;
  localparam int MAXC   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_valid = 1'b0;
  logic [SW-1:0] sample = '0;
  logic [SW-1:0] threshold = '0;
  logic          bin_tick = 1'b0;
  logic          rev_mark = 1'b0;
  logic [2:0]    rd_addr = '0;
  logic [CW-1:0] rd_data, snap_total, snap_spill;
  logic          snap_ready, snap_overflow, snap_missed;

  turn_hist #(.NUM_BINS(NB), .CNT_W(CW), .SAMPLE_W(SW), .PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
    .threshold(threshold), .bin_tick(bin_tick), .rev_mark(rev_mark),
    .rd_addr(rd_addr), .rd_data(rd_data), .snap_ready(snap_ready),
    .snap_total(snap_total), .snap_spill(snap_spill),
    .snap_overflow(snap_overflow), .snap_missed(snap_missed));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      check(1'b0, "watchdog expired", cyc, 200000);
      finish_run();
    end
  end

  // behavioural reference
  int m_hist[2][NB];
  int m_acc, m_idx, m_pcnt, m_total, m_spill, m_ccnt;
  bit m_prev, m_hit, m_clr, m_ovf, m_miss, m_snapped, m_rdv;
  int m_stot, m_sspill, m_rd;
  bit m_ready, m_sovf, m_smiss;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_hist[b, i]) m_hist[b][i] = 0;
      m_acc = 0; m_idx = 0; m_pcnt = 0; m_total = 0; m_spill = 0; m_ccnt = 0;
      m_prev = 0; m_hit = 0; m_clr = 1; m_ovf = 0; m_miss = 0;
      m_snapped = 0; m_rdv = 0; m_stot = 0; m_sspill = 0; m_rd = 0;
      m_ready = 0; m_sovf = 0; m_smiss = 0;
    end else begin
      bit ab, ev, cl, sn;
      ab = sample_valid && (int'(sample) > int'(threshold));   // R1
      ev = ab && !m_prev;
      if (sample_valid) m_prev = ab;
      cl = bin_tick || rev_mark;
      sn = (m_pcnt == PERIOD - 1);
      m_rdv = m_snapped;
      m_rd = m_hist[1 - m_acc][rd_addr];
      if (!m_clr && (cl || sn) && (m_hit || ev)) begin          // R3, R6
        if (m_hist[m_acc][m_idx] == MAXC) m_ovf = 1;            // R4
        else m_hist[m_acc][m_idx]++;
      end
      if (ev && m_total < MAXC) m_total++;
      if (m_clr && ev && m_spill < MAXC) m_spill++;             // R7
      if (bin_tick && !rev_mark && m_idx == NB - 1) m_miss = 1; // R10
      m_hit = (m_clr || sn || cl) ? 1'b0 : (m_hit || ev);
      if (rev_mark) m_idx = 0;                                  // R2
      else if (bin_tick) m_idx = (m_idx + 1) % NB;
      if (m_clr) begin
        m_hist[m_acc][m_ccnt] = 0;
        m_ccnt++;
        if (m_ccnt == NB) m_clr = 0;
      end
      m_ready = sn;
      if (sn) begin
        m_stot = m_total; m_sspill = m_spill; m_sovf = m_ovf; m_smiss = m_miss;
        m_total = 0; m_spill = 0; m_ovf = 0; m_miss = 0;
        m_acc = 1 - m_acc; m_clr = 1; m_ccnt = 0; m_pcnt = 0; m_snapped = 1;
      end else m_pcnt++;
    end
  end

  task automatic compare();
    check(snap_ready == m_ready, "R5 snap_ready", snap_ready, m_ready);
    check(int'(snap_total) == m_stot, "R8 snap_total", snap_total, m_stot);
    check(int'(snap_spill) == m_sspill, "R7 snap_spill", snap_spill, m_sspill);
    check(snap_overflow == m_sovf, "R4 snap_overflow", snap_overflow, m_sovf);
    check(snap_missed == m_smiss, "R10/R2 snap_missed", snap_missed, m_smiss);
    if (m_rdv)
      check(int'(rd_data) == m_rd, "R9/R3/R1/R6 rd_data", rd_data, m_rd);
  endtask

  task automatic drive(input int p, input int c);
    rd_addr <= 3'(c);
    case (p)
      0: begin                       // random strobes, markers and samples
        threshold    <= 10'd512;
        bin_tick     <= ($urandom % 3) == 0;
        rev_mark     <= ($urandom % 20) == 0;
        sample_valid <= ($urandom % 4) != 0;
        sample       <= SW'($urandom % 1024);
      end
      1: begin                       // no markers: wraps, low threshold
        threshold    <= 10'd100;
        bin_tick     <= (c % 2) == 0;
        rev_mark     <= 1'b0;
        sample_valid <= ($urandom % 5) != 0;
        sample       <= SW'(80 + $urandom % 40);
      end
      2: begin                       // saturation: strobe each cycle, crossing every other
        threshold    <= 10'd500;
        bin_tick     <= 1'b1;
        rev_mark     <= 1'b0;
        sample_valid <= 1'b1;
        sample       <= (c % 2) ? 10'd900 : 10'd10;
      end
      default: begin                 // held above threshold, markers coinciding with strobes
        threshold    <= 10'd300;
        bin_tick     <= ($urandom % 2) == 0;
        rev_mark     <= ($urandom % 4) == 0;
        sample_valid <= ($urandom % 2) == 0;
        sample       <= (c % 50 < 40) ? 10'd1000 : 10'd0;
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(snap_ready == 1'b0, "R5 reset snap_ready", snap_ready, 0);
    check(snap_total == '0, "R8 reset snap_total", snap_total, 0);
    check(snap_spill == '0, "R7 reset snap_spill", snap_spill, 0);
    check(snap_overflow == 1'b0, "R4 reset snap_overflow", snap_overflow, 0);
    check(snap_missed == 1'b0, "R10 reset snap_missed", snap_missed, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 3 * PERIOD; c++) begin
        @(negedge clk);
        compare();
        drive(p, c);
      end
    end
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule